// File: doc/BRIEF.md
# Pseudorandom Test Word Generator

This block produces the two pseudorandom bit streams used to check a serial data link from the receiving side. It replaces converter samples at the input of the output formatter. Each stream is cut into 10-bit words, and the earliest bit of each word goes into the most significant position. One word comes out for every sample clock on which the step input is high. A single mode input picks one of two streams:

- a short stream with a period of 511 bits;
- a long stream with a period of 8,388,607 bits.

Neither stream starts from the all-ones state. Each loads a fixed non-trivial seed. The long stream is also sent out inverted. Because of this, a receiver can confirm alignment from the first three words after a restart.

The restart input reloads the seed of the selected stream. A change of the mode input also reloads the seed. If the step input is high in the same cycle, the first word is produced at once. The word-valid output marks every cycle in which a new word was registered.

Top module: `pn_test_gen`

## Requirements
- R1: While reset is asserted, and at the first clock after it, `word_vld` is 0 and `word` is 0x000. Both generators hold their seeds: short 0x0DF, long 0x0A6E02.
- R2: With `mode_long`=0, after reset or restart, the first three words are 0x37E, 0x135 and 0x0CC.
- R3: The short stream obeys b[n] = b[n-9] XOR b[n-5]. Its seed supplies b[0..8], MSB = b[0]. The emitted bits are b[1], b[2], and so on. The stream repeats every 511 bits, so word 512 equals word 1.
- R4: With `mode_long`=1, after restart or a mode change, the first three words are 0x359, 0x07F and 0x170.
- R5: The long stream obeys b[n] = b[n-23] XOR b[n-18]. Its seed supplies b[0..22], MSB = b[0]. The emitted bits are the inverse of b[1], b[2], and so on.
- R6: Within a word, the earliest emitted bit is in bit 9 and the latest is in bit 0. Every word is 10 bits wide, whichever stream is selected.
- R7: While `step_en` is 0, `word` holds its value and the stream does not advance. The next step continues from where the stream stopped.
- R8: `restart`=1 reloads the selected seed. If `step_en`=1 in that same cycle, the word registered at that edge is already the first word of the stream.
- R9: A change of `mode_long` from one cycle to the next reloads the seed of the newly selected stream, exactly as a restart does.
- R10: `word_vld` is high in the cycle after each clock edge at which `step_en` was 1, and low otherwise. `word` changes at that same edge.
- R11: Neither generator state is ever all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_long | input | 1 | 0 selects the 511-bit stream, 1 selects the long stream |
| restart | input | 1 | Reload the seed of the selected stream |
| step_en | input | 1 | Produce one word at this edge |
| word | output | 10 | Latest test word, earliest bit in bit 9 |
| word_vld | output | 1 | A new word was registered at the last edge |

## Verification
A wrong seed or a wrong tap shows up in the very first word after a restart. The bench checks that word against the fixed values and also against a model that works bit by bit. A fault that appears only deep in the recurrence, or only near the end of the short period, shows up in the first word that uses the bad bit. It also shows up at word 512, which must match word 1. A generator that locks at zero, or that advances while idle, shows up in the next word. That word either repeats or fails to continue the model's stream.

// File: rtl/pn_pkg.sv
package pn_pkg;

  localparam int PN_MAX_LEN = 23;
  localparam int PN_WORD_W  = 10;

  typedef struct packed {
    logic [PN_MAX_LEN-1:0] st;
    logic [PN_WORD_W-1:0]  wd;
  } pn_adv_t;

  // Advance a LEN-bit register by PN_WORD_W bit steps.
  // feedback = r[len-1] ^ r[tap]; register shifts left with feedback at bit 0;
  // emitted bit after each shift is r[len-1] (optionally inverted).
  function automatic pn_adv_t pn_run(input logic [PN_MAX_LEN-1:0] st_in,
                                     input int len, input int tap,
                                     input logic inv);
    pn_adv_t r;
    logic fb;
    r.st = st_in;
    r.wd = '0;
    for (int i = 0; i < PN_WORD_W; i++) begin
      fb = r.st[len-1] ^ r.st[tap];
      r.st = {r.st[PN_MAX_LEN-2:0], fb};
      for (int j = 0; j < PN_MAX_LEN; j++) begin
        if (j >= len) r.st[j] = 1'b0;
      end
      r.wd[PN_WORD_W-1-i] = r.st[len-1] ^ inv;
    end
    return r;
  endfunction

endpackage

// File: rtl/pn_mode_ctrl.sv
module pn_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_long,
  input  logic restart,
  input  logic step_en,
  output logic reload,
  output logic step_short,
  output logic step_long,
  output logic mode_chg
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_long;
  end

  assign mode_chg   = mode_long ^ mode_q;
  assign reload     = restart | mode_chg;
  assign step_short = step_en & ~mode_long;
  assign step_long  = step_en &  mode_long;
endmodule

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core
  import pn_pkg::*;
#(
  parameter int                    LEN  = 9,
  parameter int                    TAP  = 4,
  parameter logic [PN_MAX_LEN-1:0] SEED = 23'h0000DF,
  parameter logic                  INV  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reload,
  input  logic                  step,
  output logic [PN_MAX_LEN-1:0] state_o,
  output logic [PN_WORD_W-1:0]  word_nxt
);
  logic [PN_MAX_LEN-1:0] st_q;
  logic [PN_MAX_LEN-1:0] base;
  pn_adv_t               adv;

  assign base     = reload ? SEED : st_q;
  assign adv      = pn_run(base, LEN, TAP, INV);
  assign word_nxt = adv.wd;
  assign state_o  = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= SEED;
    else if (step)   st_q <= adv.st;
    else if (reload) st_q <= SEED;
  end
endmodule

// File: rtl/pn_test_gen.sv
module pn_test_gen
  import pn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_long,
  input  logic                 restart,
  input  logic                 step_en,
  output logic [PN_WORD_W-1:0] word,
  output logic                 word_vld
);
  localparam int SHORT_LEN = 9;
  localparam int SHORT_TAP = SHORT_LEN - 5;
  localparam int LONG_LEN  = PN_MAX_LEN;
  localparam int LONG_TAP  = LONG_LEN - 6;

  logic                  reload, step_short, step_long, mode_chg;
  logic [PN_MAX_LEN-1:0] s_state, l_state;
  logic [PN_WORD_W-1:0]  s_word, l_word;
  logic [PN_WORD_W-1:0]  word_q;
  logic                  vld_q;

  pn_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .restart(restart),
    .step_en(step_en), .reload(reload), .step_short(step_short),
    .step_long(step_long), .mode_chg(mode_chg)
  );

  pn_lfsr_core #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .SEED(23'h0000DF), .INV(1'b0)) u_short (
    .clk(clk), .rst_n(rst_n), .reload(reload), .step(step_short),
    .state_o(s_state), .word_nxt(s_word)
  );

  pn_lfsr_core #(.LEN(LONG_LEN), .TAP(LONG_TAP), .SEED(23'h0A6E02), .INV(1'b1)) u_long (
    .clk(clk), .rst_n(rst_n), .reload(reload), .step(step_long),
    .state_o(l_state), .word_nxt(l_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= step_en;
      if (step_en) word_q <= mode_long ? l_word : s_word;
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/pn_test_gen_chk.sv
module pn_test_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_long,
  input logic        restart,
  input logic        step_en,
  input logic        reload,
  input logic [22:0] s_state,
  input logic [22:0] l_state,
  input logic [9:0]  word,
  input logic        word_vld
);
  assert_vld_follows_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> word_vld);
  assert_no_vld_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !word_vld);
  assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(word));
  assert_short_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_state != 23'd0);
  assert_long_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    l_state != 23'd0);
  assert_short_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && step_en && !mode_long) |=> (word == 10'h37E));
  assert_long_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && step_en && mode_long) |=> (word == 10'h359));
  assert_mode_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && (mode_long != $past(mode_long))) |-> reload);
endmodule

bind pn_test_gen pn_test_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .restart(restart),
  .step_en(step_en), .reload(reload), .s_state(s_state), .l_state(l_state),
  .word(word), .word_vld(word_vld)
);

// File: tb/pn_test_gen_bench.sv
module pn_test_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_long = 1'b0;
  logic       restart = 1'b0;
  logic       step_en = 1'b0;
  logic [9:0] word;
  logic       word_vld;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  int q[$];
  int m_mode = 0;
  int exp_word = 0;
  int exp_vld = 0;
  int words_out[$];

  always #4 clk = ~clk;

  pn_test_gen u_pn_test_gen (
    .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .restart(restart),
    .step_en(step_en), .word(word), .word_vld(word_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_seed(input int lng);
    int s, l;
    q.delete();
    s = lng ? 32'h0A6E02 : 32'h0DF;
    l = lng ? 23 : 9;
    for (int i = l - 1; i >= 0; i--) q.push_back((s >> i) & 1);
  endtask

  // behavioural stream model: b[n] = b[n-L] ^ b[n-K]
  function automatic int model_word(input int lng);
    int l, k, w, nb;
    l = lng ? 23 : 9;
    k = lng ? 18 : 5;
    w = 0;
    for (int i = 0; i < 10; i++) begin
      nb = q[0] ^ q[l - k];
      q.push_back(nb);
      void'(q.pop_front());
      w = (w << 1) | (q[0] ^ lng);
    end
    return w;
  endfunction

  task automatic cyc(input int stp, input int rst_seq, input int mode, input string req);
    step_en   = stp[0];
    restart   = rst_seq[0];
    mode_long = mode[0];
    if (rst_seq != 0 || mode != m_mode) model_seed(mode);
    m_mode = mode;
    if (stp != 0) exp_word = model_word(mode);
    exp_vld = stp;
    @(posedge clk);
    @(negedge clk);
    chk({req, " R10 vld"}, int'(word_vld), exp_vld);
    chk({req, " R3/R5 word"}, int'(word), exp_word);
    if (stp != 0) words_out.push_back(int'(word));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    model_seed(0);
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", int'(word_vld), 0);
    chk("R1 word in reset", int'(word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", int'(word_vld), 0);
    chk("R1 word after reset", int'(word), 0);

    // R2, R6: first short words
    words_out.delete();
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R2");
    chk("R2 word1", words_out[0], 'h37E);
    chk("R2 word2", words_out[1], 'h135);
    chk("R6 word3", words_out[2], 'h0CC);

    // R3: period of 511 bits
    words_out.delete();
    cyc(1, 1, 0, "R8");
    for (int i = 1; i < 512; i++) cyc(1, 0, 0, "R3");
    chk("R3 word 512 equals word 1", words_out[511], words_out[0]);
    chk("R3 word 512 literal", words_out[511], 'h37E);

    // R7: idle cycles hold and do not advance
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, "R7 idle");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R7 resume");

    // R8: restart without step, then step
    cyc(0, 1, 0, "R8 restart idle");
    cyc(1, 0, 0, "R8 first after restart");
    chk("R8 first word", int'(word), 'h37E);

    // R4, R9: switch to long stream
    words_out.delete();
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, "R4");
    chk("R4 word1", words_out[0], 'h359);
    chk("R4 word2", words_out[1], 'h07F);
    chk("R4 word3", words_out[2], 'h170);
    for (int i = 0; i < 400; i++) cyc(1, 0, 1, "R5");

    // R9: back to short with idle mode switch
    cyc(0, 0, 0, "R9 switch idle");
    cyc(1, 0, 0, "R9 first short");
    chk("R9 short reseeded", int'(word), 'h37E);
    cyc(1, 0, 1, "R9 switch with step");
    chk("R9 long reseeded", int'(word), 'h359);

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc((r < 70) ? 1 : 0, (r > 95) ? 1 : 0, (r == 50 || r == 51) ? (1 - m_mode) : m_mode, "R11 mixed");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule